// File: doc/BRIEF.md
# Fused macro-op pair former

This block sits between an instruction fetch buffer and the next decode stage. The fetch side delivers a halfword-aligned window of up to two 16-bit halfwords per cycle. The block keeps them in a small halfword queue and cuts the stream into instructions of one or two halfwords. It then forms macro-ops from those instructions. An instruction whose fuse flag is set is joined with the instruction right after it. Each output transfer is either one fused pair or one unfused instruction.

Both slots of an output entry use the same three-register internal layout. A short 16-bit two-operand instruction is widened so that its first register field acts as both destination and first source. A long 32-bit instruction carries its three register fields and a 12-bit immediate. Pairs are formed only behind a single-cycle ALU head. A flagged head that is not a single-cycle ALU operation is sent as two separate singles, and a sticky flag records the event.

The controller has two named states. `ST_FREE` honours the fuse flag of the instruction at the queue head. `ST_SOLO` means that the instruction at the head is the tail of a broken pair, so its fuse flag is ignored and it leaves as a single. Transitions:
- `ST_FREE -> ST_SOLO` when a split head is transferred out.
- `ST_SOLO -> ST_FREE` when the next instruction is transferred out.
- Any state goes to `ST_FREE` on flush.

Top module: `fuse_pair_former`

## Requirements
- R1: Bit 1 of an instruction's first halfword gives its length: 0 means one halfword (16-bit), 1 means two halfwords (32-bit, first halfword in bits 15:0). An unfused instruction leaves as a single: out_pair low, out_hw_cnt equal to its length, out_slot1 all zero.
- R2: A 32-bit instruction expands to: opcode bits 7:2, dest bits 11:8, src1 bits 15:12, src2 bits 19:16, immediate bits 31:20, length bit 1.
- R3: A 16-bit instruction expands to: opcode bits 7:2, dest = src1 = bits 11:8, src2 bits 15:12, immediate 0, length bit 0.
- R4: When bit 0 (fuse flag) of an instruction is set and its opcode is below 16 (single-cycle ALU), it leaves together with the following instruction as a pair: out_pair high, head in out_slot0, tail in out_slot1, out_hw_cnt equal to the sum of both lengths (2 to 4).
- R5: The fuse flag of the tail of a pair is not used: the instruction after that tail is handled on its own flag.
- R6: A head with its fuse flag set and an opcode of 16 or above leaves as a single. The instruction after it also leaves as a single whatever its own fuse flag says. out_illegal_fuse then goes high and stays high until reset.
- R7: While a fused ALU head is present but its tail is not yet complete in the queue, out_valid stays low and the head is never sent alone.
- R8: An entry offered with out_ready low stays unchanged until it is taken. Entries leave in stream order, with none lost and none repeated.
- R9: A window carries in_hw_cnt halfwords, lower halfword first. It is accepted when in_valid and in_ready are high. in_ready is high only when those halfwords fit in the 4-halfword queue.
- R10: flush empties the queue and returns the controller to `ST_FREE` in the same cycle. out_valid is low during and after the flush cycle, and a window offered during flush is dropped. out_illegal_fuse is not cleared by flush.
- R11: After reset, out_valid is low, in_ready is high and out_illegal_fuse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empties the queue and clears partial pair state |
| in_valid | input | 1 | Fetch window valid |
| in_ready | output | 1 | Window fits in the queue |
| in_hw_cnt | input | 2 | Number of halfwords in the window (1 or 2) |
| in_data | input | 32 | Window, first halfword in bits 15:0 |
| out_valid | output | 1 | Output entry valid |
| out_ready | input | 1 | Decode stage takes the entry |
| out_pair | output | 1 | Entry is a fused pair |
| out_hw_cnt | output | 3 | Halfwords consumed by the entry |
| out_slot0 | output | 31 | Head slot: [30] long, [29:24] opcode, [23:20] dest, [19:16] src1, [15:12] src2, [11:0] immediate |
| out_slot1 | output | 31 | Tail slot, same layout, zero for singles |
| out_illegal_fuse | output | 1 | Sticky: a fuse flag stood on a non-ALU head |

## Verification
The bench runs four kinds of stream, and each one separates a different fault:
- Unfused mixed-length streams separate length decoding from field expansion.
- Pairs in all four length combinations, with ALU opcodes 0 and 15 at the head, expose wrong halfword counts and a wrong tail start.
- Tails that carry a set fuse flag, and a split head at opcode 16, show whether the tail flag chains or a split state is forgotten.
- A tail delivered one halfword at a time, random output back-pressure, and flushes with a partial pair, a pending split and a dropped window check stalling, holding and clearing.

// File: rtl/fuse_pkg.sv
`timescale 1ns/1ps
package fuse_pkg;
    localparam int HW_W   = 16;
    localparam int OP_W   = 6;
    localparam int REG_W  = 4;
    localparam int IMM_W  = 12;
    localparam int SLOT_W = 1 + OP_W + 3 * REG_W + IMM_W;
    localparam int MAX_HW = 4;
    localparam int HWC_W  = $clog2(MAX_HW + 1);

    typedef struct packed {
        logic             is_long;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
        logic [IMM_W-1:0] imm;
    } slot_t;

    typedef enum logic [0:0] {
        ST_FREE = 1'b0,
        ST_SOLO = 1'b1
    } fstate_e;
endpackage

// File: rtl/fuse_expand.sv
`timescale 1ns/1ps
module fuse_expand
    import fuse_pkg::*;
(
    input  logic [2*HW_W-1:0] raw,
    output slot_t             slot
);
    always_comb begin
        slot     = '0;
        slot.op  = raw[7:2];
        slot.rd  = raw[11:8];
        if (raw[1]) begin
            slot.is_long = 1'b1;
            slot.rs1     = raw[15:12];
            slot.rs2     = raw[19:16];
            slot.imm     = raw[31:20];
        end else begin
            // two-operand short form: first field is source and destination
            slot.rs1 = raw[11:8];
            slot.rs2 = raw[15:12];
        end
    end
endmodule

// File: rtl/fuse_hw_queue.sv
`timescale 1ns/1ps
module fuse_hw_queue #(
    parameter int DEPTH = 4,
    parameter int IN_HW = 2,
    parameter int HW_W  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PC_W  = $clog2(IN_HW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [PC_W-1:0]       push_cnt,
    input  logic [IN_HW*HW_W-1:0] push_data,
    input  logic [CNT_W-1:0]      pop_cnt,
    output logic [DEPTH*HW_W-1:0] q_flat,
    output logic [CNT_W-1:0]      cnt
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [HW_W-1:0]  mem     [DEPTH];
    logic [HW_W-1:0]  mem_nxt [DEPTH];
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        int keep;
        int src;
        int dst;
        keep = int'(cnt) - int'(pop_cnt);
        for (int i = 0; i < DEPTH; i++) begin
            src = i + int'(pop_cnt);
            mem_nxt[i] = '0;
            if (src < int'(cnt)) begin
                mem_nxt[i] = mem[src[IDX_W-1:0]];
            end
        end
        for (int j = 0; j < IN_HW; j++) begin
            dst = keep + j;
            if (j < int'(push_cnt) && dst < DEPTH) begin
                mem_nxt[dst[IDX_W-1:0]] = push_data[j*HW_W +: HW_W];
            end
        end
        cnt_nxt = CNT_W'(keep + int'(push_cnt));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            cnt <= cnt_nxt;
            mem <= mem_nxt;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
        assign q_flat[g*HW_W +: HW_W] = mem[g];
    end
endmodule

// File: rtl/fuse_ctrl.sv
`timescale 1ns/1ps
module fuse_ctrl
    import fuse_pkg::*;
#(
    parameter int ALU_LIMIT = 16,
    parameter int CNT_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [7:0]       head_lo,
    input  logic             hw1_long,
    input  logic             hw2_long,
    input  logic [CNT_W-1:0] cnt,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             out_pair,
    output logic [HWC_W-1:0] hw_used,
    output logic             tail_at2,
    output logic             illegal_flag
);
    fstate_e          state, state_nxt;
    logic [HWC_W-1:0] len0, len1;
    logic             tail_long, have_head, have_pair;
    logic             fuse_req, head_alu, split, fire;

    assign len0      = head_lo[1] ? HWC_W'(2) : HWC_W'(1);
    assign tail_long = head_lo[1] ? hw2_long : hw1_long;
    assign len1      = tail_long ? HWC_W'(2) : HWC_W'(1);
    assign have_head = int'(cnt) >= int'(len0);
    assign have_pair = int'(cnt) >= int'(len0) + int'(len1);
    assign fuse_req  = head_lo[0] && (state == ST_FREE);
    assign head_alu  = int'(head_lo[7:2]) < ALU_LIMIT;
    assign tail_at2  = head_lo[1];
    assign fire      = out_valid && out_ready;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_FREE;
            illegal_flag <= 1'b0;
        end else begin
            state <= state_nxt;
            if (fire && split) begin
                illegal_flag <= 1'b1;
            end
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FREE: if (fire && split) state_nxt = ST_SOLO;
            ST_SOLO: if (fire)          state_nxt = ST_FREE;
        endcase
        if (flush) begin
            state_nxt = ST_FREE;
        end
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_pair  = 1'b0;
        hw_used   = '0;
        split     = 1'b0;
        if (!flush && have_head) begin
            if (!fuse_req) begin
                out_valid = 1'b1;
                hw_used   = len0;
            end else if (!head_alu) begin
                out_valid = 1'b1;
                hw_used   = len0;
                split     = 1'b1;
            end else if (have_pair) begin
                out_valid = 1'b1;
                out_pair  = 1'b1;
                hw_used   = len0 + len1;
            end
        end
    end
endmodule

// File: rtl/fuse_pair_former.sv
`timescale 1ns/1ps
module fuse_pair_former
    import fuse_pkg::*;
#(
    parameter int Q_DEPTH   = 4,
    parameter int IN_HW     = 2,
    parameter int ALU_LIMIT = 16,
    localparam int CNT_W    = $clog2(Q_DEPTH + 1),
    localparam int PC_W     = $clog2(IN_HW + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [PC_W-1:0]       in_hw_cnt,
    input  logic [IN_HW*HW_W-1:0] in_data,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic                  out_pair,
    output logic [HWC_W-1:0]      out_hw_cnt,
    output logic [SLOT_W-1:0]     out_slot0,
    output logic [SLOT_W-1:0]     out_slot1,
    output logic                  out_illegal_fuse
);
    logic [CNT_W-1:0]          q_cnt, pop_cnt;
    logic [PC_W-1:0]           push_cnt;
    logic [Q_DEPTH*HW_W-1:0]   q_flat;
    logic [HWC_W-1:0]          hw_used;
    logic                      tail_at2;
    logic [2*HW_W-1:0]         raw  [2];
    slot_t                     slot [2];

    assign in_ready = (int'(q_cnt) + int'(in_hw_cnt)) <= Q_DEPTH;
    assign push_cnt = (in_valid && in_ready && !flush) ? in_hw_cnt : '0;
    assign pop_cnt  = (out_valid && out_ready) ? CNT_W'(hw_used) : '0;

    fuse_hw_queue #(.DEPTH(Q_DEPTH), .IN_HW(IN_HW), .HW_W(HW_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push_cnt  (push_cnt),
        .push_data (in_data),
        .pop_cnt   (pop_cnt),
        .q_flat    (q_flat),
        .cnt       (q_cnt)
    );

    fuse_ctrl #(.ALU_LIMIT(ALU_LIMIT), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush),
        .head_lo      (q_flat[7:0]),
        .hw1_long     (q_flat[HW_W+1]),
        .hw2_long     (q_flat[2*HW_W+1]),
        .cnt          (q_cnt),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .out_pair     (out_pair),
        .hw_used      (hw_used),
        .tail_at2     (tail_at2),
        .illegal_flag (out_illegal_fuse)
    );

    assign raw[0] = q_flat[2*HW_W-1:0];
    assign raw[1] = tail_at2 ? q_flat[4*HW_W-1:2*HW_W] : q_flat[3*HW_W-1:HW_W];

    for (genvar s = 0; s < 2; s++) begin : g_slot
        fuse_expand u_exp (
            .raw  (raw[s]),
            .slot (slot[s])
        );
    end

    assign out_hw_cnt = out_valid ? hw_used : '0;
    assign out_slot0  = out_valid ? slot[0] : '0;
    assign out_slot1  = out_pair  ? slot[1] : '0;
endmodule

// File: rtl/fuse_pair_former_chk.sv
`timescale 1ns/1ps
module fuse_pair_former_chk #(
    parameter int Q_DEPTH   = 4,
    parameter int ALU_LIMIT = 16,
    localparam int CNT_W    = $clog2(Q_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             out_valid,
    input logic             out_ready,
    input logic             out_pair,
    input logic [2:0]       out_hw_cnt,
    input logic [30:0]      out_slot0,
    input logic [30:0]      out_slot1,
    input logic             out_illegal_fuse,
    input logic [CNT_W-1:0] q_cnt
);
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !flush) |=> (flush || (out_valid && $stable(out_pair)
            && $stable(out_hw_cnt) && $stable(out_slot0) && $stable(out_slot1))));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q_cnt) <= Q_DEPTH);

    // R4
    pair_head_alu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pair) |-> (int'(out_slot0[29:24]) < ALU_LIMIT));

    // R4
    pair_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_pair) |-> (out_hw_cnt >= 3'd2 && out_hw_cnt <= 3'd4));

    // R6
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal_fuse |=> out_illegal_fuse);

    // R1
    single_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_pair) |-> (out_slot1 == '0
            && out_hw_cnt == (out_slot0[30] ? 3'd2 : 3'd1)));

    // R3
    short_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_slot0[30]) |-> (out_slot0[23:20] == out_slot0[19:16]
            && out_slot0[11:0] == '0));
endmodule

bind fuse_pair_former fuse_pair_former_chk #(.Q_DEPTH(Q_DEPTH), .ALU_LIMIT(ALU_LIMIT)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .flush            (flush),
    .out_valid        (out_valid),
    .out_ready        (out_ready),
    .out_pair         (out_pair),
    .out_hw_cnt       (out_hw_cnt),
    .out_slot0        (out_slot0),
    .out_slot1        (out_slot1),
    .out_illegal_fuse (out_illegal_fuse),
    .q_cnt            (q_cnt)
);

// File: tb/tb_fuse_pair_former.sv
`timescale 1ns/1ps
module tb_fuse_pair_former;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_hw_cnt = '0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_pair;
    logic [2:0]  out_hw_cnt;
    logic [30:0] out_slot0, out_slot1;
    logic        out_illegal_fuse;

    int checks = 0;
    int errors = 0;
    bit bp_mode = 1'b0;
    int bp_cnt = 0;

    logic [15:0] stream [$];
    logic [65:0] exp_q  [$];
    string       tag_q  [$];

    always #5 clk = ~clk;

    fuse_pair_former dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready), .in_hw_cnt(in_hw_cnt), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_pair(out_pair),
        .out_hw_cnt(out_hw_cnt), .out_slot0(out_slot0), .out_slot1(out_slot1),
        .out_illegal_fuse(out_illegal_fuse)
    );

    task automatic chk(bit ok, string req, string what, logic [65:0] act, logic [65:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] i16(bit f, int op, int ra, int rb);
        return {rb[3:0], ra[3:0], op[5:0], 1'b0, f};
    endfunction

    task automatic add16(bit f, int op, int ra, int rb);
        stream.push_back(i16(f, op, ra, rb));
    endtask

    task automatic add32(bit f, int op, int rd, int rs1, int rs2, int imm);
        logic [31:0] w;
        w = {imm[11:0], rs2[3:0], rs1[3:0], rd[3:0], op[5:0], 1'b1, f};
        stream.push_back(w[15:0]);
        stream.push_back(w[31:16]);
    endtask

    // expected slot from the field positions in R2 and R3
    function automatic logic [30:0] exp_slot(logic [31:0] raw);
        logic [30:0] s;
        s = '0;
        s[29:24] = raw[7:2];
        s[23:20] = raw[11:8];
        if (raw[1]) begin
            s[30]    = 1'b1;
            s[19:16] = raw[15:12];
            s[15:12] = raw[19:16];
            s[11:0]  = raw[31:20];
        end else begin
            s[19:16] = raw[11:8];
            s[15:12] = raw[15:12];
        end
        return s;
    endfunction

    function automatic logic [31:0] word_at(int i);
        logic [15:0] hi;
        hi = (stream[i][1] && i + 1 < stream.size()) ? stream[i+1] : 16'h0;
        return {hi, stream[i]};
    endfunction

    // scoreboard driver side: expected entries from R1, R4, R5, R6
    task automatic model(string tag);
        int  i = 0;
        bit  solo = 0;
        int  l0, l1;
        while (i < stream.size()) begin
            l0 = stream[i][1] ? 2 : 1;
            if (stream[i][0] && !solo && stream[i][7:2] < 6'd16) begin
                l1 = stream[i+l0][1] ? 2 : 1;
                exp_q.push_back({1'b1, 3'(l0 + l1), exp_slot(word_at(i)), exp_slot(word_at(i + l0))});
                tag_q.push_back(tag);
                i = i + l0 + l1;
                solo = 0;
            end else begin
                exp_q.push_back({1'b0, 3'(l0), exp_slot(word_at(i)), 31'h0});
                tag_q.push_back(tag);
                solo = stream[i][0] && !solo;
                i = i + l0;
            end
        end
    endtask

    task automatic feed_range(int from, int to);
        int idx = from;
        bit alt = 1;
        int k;
        while (idx < to) begin
            @(negedge clk);
            k = (to - idx >= 2 && alt) ? 2 : 1;
            alt = !alt;
            in_valid  = 1'b1;
            in_hw_cnt = 2'(k);
            in_data   = {(k == 2) ? stream[idx+1] : 16'h0, stream[idx]};
            #1;
            if (in_ready) idx = idx + k;
        end
        @(negedge clk);
        in_valid  = 1'b0;
        in_hw_cnt = '0;
    endtask

    task automatic drain(string tag);
        int t = 0;
        while (exp_q.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, tag, "all expected entries produced", 66'(exp_q.size()), 66'd0);
    endtask

    task automatic run(string tag);
        model(tag);
        feed_range(0, stream.size());
        drain(tag);
        stream.delete();
    endtask

    // scoreboard monitor side
    always begin
        logic [65:0] act;
        logic [65:0] e;
        string       tg;
        @(negedge clk);
        bp_cnt++;
        out_ready = bp_mode ? ((bp_cnt % 3) != 0) : 1'b1;
        #1;
        if (rst_n && out_valid && out_ready) begin
            act = {out_pair, out_hw_cnt, out_slot0, out_slot1};
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected output entry", act, 66'd0);
            end else begin
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                chk(act == e, tg, "output entry", act, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11
        chk(!out_valid, "R11", "out_valid after reset", 66'(out_valid), 66'd0);
        chk(in_ready, "R11", "in_ready after reset", 66'(in_ready), 66'd1);
        chk(!out_illegal_fuse, "R11", "flag after reset", 66'(out_illegal_fuse), 66'd0);

        // R1 R2 R3: unfused mixed lengths
        add16(0, 5, 3, 7);
        add32(0, 40, 1, 2, 3, 12'hABC);
        add16(0, 63, 15, 0);
        add32(0, 2, 14, 13, 12, 12'h001);
        add32(0, 17, 9, 8, 7, 12'hFFF);
        add16(0, 0, 6, 9);
        run("R1_R2_R3");

        // R4: pairs in all length combinations, ALU opcodes 0 and 15
        add16(1, 0, 1, 2);  add16(0, 33, 3, 4);
        add16(1, 15, 5, 6); add32(0, 20, 7, 8, 9, 12'h123);
        add32(1, 7, 1, 1, 2, 12'h456); add16(0, 50, 2, 3);
        add32(1, 15, 4, 5, 6, 12'h789); add32(0, 40, 10, 11, 12, 12'hFED);
        run("R4");

        // R5: a tail with its fuse flag set does not chain
        add16(1, 3, 1, 2);  add16(1, 20, 3, 4);  add16(0, 9, 5, 6);
        add32(1, 1, 2, 3, 4, 12'h010); add32(1, 2, 5, 6, 7, 12'h020); add16(0, 44, 8, 9);
        run("R5");
        chk(!out_illegal_fuse, "R6", "flag stays low with legal pairs", 66'(out_illegal_fuse), 66'd0);

        // R6: non-ALU head (opcode 16) splits; its tail is a single despite its flag
        add32(1, 16, 1, 2, 3, 12'h0F0); add16(1, 4, 5, 6); add16(0, 8, 7, 8);
        run("R6");
        chk(out_illegal_fuse, "R6", "flag set after split", 66'(out_illegal_fuse), 66'd1);
        add16(1, 6, 1, 2); add16(0, 7, 3, 4);
        run("R6");
        chk(out_illegal_fuse, "R6", "flag sticky", 66'(out_illegal_fuse), 66'd1);

        // R7: tail arrives one halfword at a time
        add32(1, 7, 1, 2, 3, 12'h011);
        add32(0, 33, 4, 5, 6, 12'h7FF);
        model("R7");
        feed_range(0, 3);
        repeat (4) @(negedge clk);
        #1;
        chk(!out_valid, "R7", "no output with partial tail", 66'(out_valid), 66'd0);
        feed_range(3, 4);
        drain("R7");
        stream.delete();

        // R8 R9: output back-pressure on a longer mixed stream
        bp_mode = 1'b1;
        for (int n = 0; n < 6; n++) begin
            add16(1, n, n, n + 1);
            add32(0, 30 + n, n, 2, 3, 12'h100 + n);
            add32(0, 20 + n, 1, n, 3, 12'h200 + n);
            add16(1, 14, 2, n);
            add16(n % 2, 11, 3, 4);
        end
        add16(0, 1, 1, 1);
        run("R8_R9");
        bp_mode = 1'b0;

        // R10: flush with a partial pair and a dropped window
        add32(1, 3, 1, 2, 3, 12'h333);
        add16(0, 9, 4, 5);
        feed_range(0, 2);
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, "R7", "fused head waits for tail", 66'(out_valid), 66'd0);
        @(negedge clk);
        flush     = 1'b1;
        in_valid  = 1'b1;
        in_hw_cnt = 2'd1;
        in_data   = {16'h0, i16(0, 12, 1, 2)};
        #1;
        chk(!out_valid, "R10", "out_valid low during flush", 66'(out_valid), 66'd0);
        @(negedge clk);
        flush    = 1'b0;
        in_valid = 1'b0;
        in_hw_cnt = '0;
        #1;
        chk(!out_valid, "R10", "queue empty after flush", 66'(out_valid), 66'd0);
        repeat (3) @(negedge clk);
        #1;
        chk(!out_valid, "R10", "window during flush dropped", 66'(out_valid), 66'd0);
        stream.delete();
        add16(1, 2, 6, 7); add32(0, 45, 1, 2, 3, 12'h0AA);
        run("R10");

        // R10: flush clears a pending split tail state
        add16(1, 30, 1, 2);
        run("R10");
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        add16(1, 2, 3, 4); add16(0, 9, 5, 6);
        run("R10");
        chk(out_illegal_fuse, "R10", "flush keeps sticky flag", 66'(out_illegal_fuse), 66'd1);

        chk(exp_q.size() == 0, "R8", "scoreboard empty at end", 66'(exp_q.size()), 66'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule